// File: doc/BRIEF.md
# Global Intensity Pulse-Width Sequencer

This block chooses one global brightness weight for each binary display frame. It steps through a fixed, repeating list of sixteen weights. In every group of four frames, three run at full width and the fourth runs at a reduced width. The reduced widths are 3/8, 3/16, 3/32 and 3/64 of a display clock period, in that order across the sixteen frames. Every pixel in a frame uses the same weight. Dim pixels therefore get frequent short pulses instead of rare full ones, which keeps their flashing above the flicker fusion rate.

The weight leaves the block in two forms:
- As a 10.3 fixed-point scale, equal to 1023 × width/64, for the delta-sigma feedback path.
- As a gate that sets the duty cycle of the panel's row-select clock. The block counts a fast tick clock into 64 sub-ticks per display clock period. The gate is high while the sub-tick count is below the width of the current frame.

A frame-start strobe advances the 4-bit frame index and realigns the sub-tick count to zero.

Top module: `pws_intensity_sequencer`

## Requirements
- R1: After reset, frame_idx is 0, intensity_scale is 8184 (1023.0 in 10.3) and row_clk_gate is high.
- R2: A frame_start seen at a clock edge raises frame_idx by one from the next cycle on, wrapping from 15 to 0; a strobe held high advances it on every edge.
- R3: Without frame_start, frame_idx stays unchanged however many ticks pass.
- R4: The width in 64ths for frame_idx 0..15 is 64,64,64,24, 64,64,64,12, 64,64,64,6, 64,64,64,3. Index positions 3, 7, 11 and 15 are the reduced frames.
- R5: From the cycle after frame_start, row_clk_gate is high for exactly the first width sub-ticks of each 64-tick period and low for the rest.
- R6: In a full-width frame, row_clk_gate stays high on every tick.
- R7: intensity_scale equals floor(1023 × width × 8 / 64). That is 8184 for width 64, 3069 for 24, 1534 for 12, 767 for 6 and 383 for 3.
- R8: The sub-tick count wraps after 64 ticks without a strobe, so the gate turns high again at the start of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock, 64 ticks per display clock period |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-tick strobe marking a new display frame |
| intensity_scale | output | 13 | Global weight in unsigned 10.3 fixed point |
| frame_idx | output | 4 | Current position in the 16-frame pattern |
| row_clk_gate | output | 1 | Duty-cycle enable for the row-select clock |

## Verification
The bench builds the block with its default parameters. These are 6 sub-tick bits (64 ticks per period), a 4-bit frame index, a 10-bit pixel maximum of 1023 and 3 fraction bits. With these values a full pattern cycle plus a wrap fits in a few thousand ticks, so every palette entry and the 15-to-0 index wrap can be walked tick by tick. Running each frame for 64 ticks exercises the narrowest width of 3 sub-ticks and the gate's edge at every width boundary. Running past 64 ticks exercises the period wrap.

// File: rtl/pws_pkg.sv
package pws_pkg;

  // Width in sub-ticks for a pattern position: three full frames, then
  // a reduced frame whose width halves on each successive group.
  function automatic int unsigned width_of(input int unsigned idx,
                                           input int unsigned sub_w);
    int sh;
    if ((idx & 3) != 3) begin
      return 32'd1 << sub_w;
    end
    sh = int'(sub_w) - 3 - int'(idx >> 2);
    if (sh < 0) begin
      return 32'd1;
    end
    return 32'd3 << sh;
  endfunction

  // Scale = pix_max * width / 2^sub_w, expressed with frac_w fraction bits.
  function automatic int unsigned scale_of(input int unsigned width,
                                           input int unsigned pix_max,
                                           input int unsigned sub_w,
                                           input int unsigned frac_w);
    int unsigned prod;
    prod = pix_max * width;
    return prod >> (sub_w - frac_w);
  endfunction

endpackage

// File: rtl/pws_frame_counter.sv
module pws_frame_counter #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (advance) begin
      idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/pws_subtick_counter.sv
module pws_subtick_counter #(
  parameter int unsigned SUB_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align,
  output logic [SUB_W-1:0] tick,
  output logic             wrap
);

  localparam logic [SUB_W-1:0] LAST = {SUB_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
    end else if (align) begin
      tick <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign wrap = (tick == LAST);

endmodule

// File: rtl/pws_palette.sv
module pws_palette #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned SUB_W   = 6,
  parameter int unsigned PIX_MAX = 1023,
  parameter int unsigned SCALE_W = 13,
  parameter int unsigned FRAC_W  = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [SUB_W:0]   width,
  output logic [SCALE_W-1:0] scale
);
  import pws_pkg::*;

  localparam int unsigned NUM_FRAMES = 1 << IDX_W;

  logic [SUB_W:0]     width_rom [NUM_FRAMES];
  logic [SCALE_W-1:0] scale_rom [NUM_FRAMES];

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_entry
    localparam int unsigned W = width_of(g, SUB_W);
    localparam int unsigned S = scale_of(W, PIX_MAX, SUB_W, FRAC_W);
    assign width_rom[g] = W[SUB_W:0];
    assign scale_rom[g] = S[SCALE_W-1:0];
  end

  assign width = width_rom[idx];
  assign scale = scale_rom[idx];

endmodule

// File: rtl/pws_intensity_sequencer.sv
module pws_intensity_sequencer #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned SUB_W   = 6,
  parameter int unsigned PIX_W   = 10,
  parameter int unsigned FRAC_W  = 3,
  parameter int unsigned SCALE_W = PIX_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  output logic [SCALE_W-1:0] intensity_scale,
  output logic [IDX_W-1:0]   frame_idx,
  output logic               row_clk_gate
);

  localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;

  logic [SUB_W-1:0] sub_tick;
  logic             period_wrap;
  logic [SUB_W:0]   width_now;

  pws_frame_counter #(.IDX_W(IDX_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (frame_start),
    .idx     (frame_idx)
  );

  pws_subtick_counter #(.SUB_W(SUB_W)) u_sub (
    .clk   (clk),
    .rst_n (rst_n),
    .align (frame_start),
    .tick  (sub_tick),
    .wrap  (period_wrap)
  );

  pws_palette #(
    .IDX_W   (IDX_W),
    .SUB_W   (SUB_W),
    .PIX_MAX (PIX_MAX),
    .SCALE_W (SCALE_W),
    .FRAC_W  (FRAC_W)
  ) u_pal (
    .idx   (frame_idx),
    .width (width_now),
    .scale (intensity_scale)
  );

  assign row_clk_gate = ({1'b0, sub_tick} < width_now);

endmodule

// File: rtl/pws_intensity_sequencer_chk.sv
module pws_intensity_sequencer_chk #(
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned SCALE_W    = 13,
  parameter int unsigned FULL_SCALE = 8184
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [SCALE_W-1:0] intensity_scale,
  input logic [IDX_W-1:0]   frame_idx,
  input logic               row_clk_gate,
  input logic               period_wrap
);

  // R2
  frame_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> frame_idx == $past(frame_idx) + 1'b1);

  // R3
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_idx));

  // R6
  full_gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intensity_scale == SCALE_W'(FULL_SCALE)) |-> row_clk_gate);

  // R5
  gate_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_clk_gate && !frame_start && !period_wrap) |=> !row_clk_gate);

  // R5
  gate_open_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> row_clk_gate);

  // R8
  gate_open_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_wrap && !frame_start) |=> row_clk_gate);

endmodule

bind pws_intensity_sequencer pws_intensity_sequencer_chk #(
  .IDX_W      (IDX_W),
  .SCALE_W    (SCALE_W),
  .FULL_SCALE (((1 << PIX_W) - 1) << FRAC_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .frame_start     (frame_start),
  .intensity_scale (intensity_scale),
  .frame_idx       (frame_idx),
  .row_clk_gate    (row_clk_gate),
  .period_wrap     (period_wrap)
);

// File: tb/pws_intensity_sequencer_tb.sv
module pws_intensity_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [12:0] intensity_scale;
  logic [3:0]  frame_idx;
  logic        row_clk_gate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected width (64ths) and 10.3 scale per pattern position (R4, R7)
  localparam int EXP_W [16] = '{64, 64, 64, 24, 64, 64, 64, 12,
                                64, 64, 64, 6,  64, 64, 64, 3};
  localparam int EXP_S [16] = '{8184, 8184, 8184, 3069, 8184, 8184, 8184, 1534,
                                8184, 8184, 8184, 767,  8184, 8184, 8184, 383};

  always #10 clk = ~clk;

  pws_intensity_sequencer u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start     (frame_start),
    .intensity_scale (intensity_scale),
    .frame_idx       (frame_idx),
    .row_clk_gate    (row_clk_gate)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe for one tick; returns at the negedge where sub-tick 0 is live.
  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  // Walk one 64-tick period, checking the gate shape, then the wrap.
  task automatic walk_period(input int pos);
    int highs = 0;
    int shape_bad = 0;
    for (int t = 0; t < 64; t++) begin
      if (row_clk_gate) highs++;
      if (row_clk_gate != (t < EXP_W[pos])) shape_bad++;
      @(negedge clk);
    end
    chk("R5 gate high ticks", highs, EXP_W[pos]);
    chk("R5 gate contiguous from period start", shape_bad, 0);
    if (EXP_W[pos] == 64) chk("R6 full frame gate always high", highs, 64);
    chk("R8 gate reopens after wrap", int'(row_clk_gate), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset frame_idx", int'(frame_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 frame_idx after reset", int'(frame_idx), 0);
    chk("R1 scale after reset", int'(intensity_scale), 8184);
    chk("R1 gate after reset", int'(row_clk_gate), 1);

    // Vector walk: 20 frames covers the full pattern and the 15->0 wrap
    for (int k = 1; k <= 20; k++) begin
      pulse_frame();
      chk("R2 frame_idx advances", int'(frame_idx), k % 16);
      chk("R4 R7 scale for position", int'(intensity_scale), EXP_S[k % 16]);
      walk_period(k % 16);
    end

    // R3: long idle keeps the index
    repeat (200) @(negedge clk);
    chk("R3 frame_idx held without strobe", int'(frame_idx), 4);
    chk("R3 scale held without strobe", int'(intensity_scale), EXP_S[4]);

    // R2: strobe held for three ticks advances three times
    @(negedge clk) frame_start = 1'b1;
    repeat (3) @(negedge clk);
    frame_start = 1'b0;
    chk("R2 held strobe advances per tick", int'(frame_idx), 7);
    chk("R7 scale at reduced frame 7", int'(intensity_scale), 1534);
    walk_period(7);

    // Narrowest frame after a second wrap of the sub-ticks
    repeat (8) pulse_frame();
    chk("R4 at position 15", int'(frame_idx), 15);
    walk_period(15);
    walk_period(15);

    // R1: reset mid-pattern returns to position 0
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 frame_idx in mid-pattern reset", int'(frame_idx), 0);
    chk("R1 gate in mid-pattern reset", int'(row_clk_gate), 1);
    rst_n = 1'b1;
    pulse_frame();
    chk("R2 first advance after reset", int'(frame_idx), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule